// File: doc/BRIEF.md
# Dual-Mode Vector Multiply-Accumulate Unit

This unit is the arithmetic core of a neural-network dot-product engine. On every accepted beat it takes one packed word holding two signed 16-bit input samples and one packed word holding two signed 16-bit weights, and forms the two lane products. A mode bit, sampled with each beat, selects how they are used. In dual mode the two products are added together into accumulator 0, so an even-width kernel needs half as many beats. In vector mode each lane feeds its own accumulator, so two dot products advance side by side. For a stride-one convolution with an odd-width kernel, the same weight is placed in both weight lanes and two neighbouring samples are placed in the sample lanes.

Each accumulator holds either 32 or 40 significant bits, chosen by a guard-enable pin. A sticky flag records any sum that left the active signed range. A clear pin starts a new dot product: on its own it zeroes the accumulators and the flag, and together with a beat it loads the new products in place of the old sums. The input side is a valid/ready stream. Ready is low during reset and high at all times after the first clock edge that follows reset release, so the unit never applies back-pressure. A producer may hold valid high on consecutive cycles, and each cycle with both valid and ready high counts as one beat. The result side is a single-cycle strobe with no back-pressure. Both accumulators can be read at any time.

Top module: `vmac_unit`

## Requirements
- R1: `in_ready` is high in every cycle after the first clock edge that follows reset release. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. `res_valid` is high for exactly the one cycle after each accepted beat and low otherwise.
- R2: Lane 0 uses sample A1 = `in_samples[15:0]` and weight B1 = `in_weights[15:0]`. Lane 1 uses A2 = `in_samples[31:16]` and B2 = `in_weights[31:16]`. All four values are signed two's complement. With `in_mode` = 0 (dual), an accepted beat adds A1*B1 + A2*B2 to accumulator 0.
- R3: In dual mode without clear, accumulator 1 keeps its value across an accepted beat.
- R4: With `in_mode` = 1 (vector), an accepted beat adds A1*B1 to accumulator 0 and A2*B2 to accumulator 1. This includes the stride-one case where B1 equals B2.
- R5: An accepted beat is visible on the accumulator outputs in the cycle after its accepting edge. In a cycle with no accepted beat and no clear, neither accumulator changes.
- R6: `in_clear` high without an accepted beat sets both accumulators and the overflow flag to zero at the next edge.
- R7: `in_clear` high together with an accepted beat discards the old sums. Each accumulator that the mode updates is loaded with the new beat's contribution alone. In dual mode accumulator 1 is zeroed.
- R8: With `guard_en` low, each update wraps at 32 bits. Bits 39:32 of the output copy bit 31. For example, a dual beat with all four operands equal to -32768, loaded by clear, gives 0xFF80000000.
- R9: With `guard_en` high, sums are kept to 40 bits with no wrap below ±2^39. For example, four such dual beats after a clear give 0x0200000000 with the flag low.
- R10: `ovf` is set when any update's exact sum falls outside the signed range of the active width (32 or 40 bits). It stays set until a clear or reset. An overflow produced by a clear-load beat still sets it.
- R11: During reset, both accumulators are zero and `ovf`, `res_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Unit accepts a beat |
| in_mode | input | 1 | 0 = dual (sum both lanes), 1 = vector (per-lane accumulators) |
| in_clear | input | 1 | Start a new dot product |
| in_samples | input | 32 | Packed samples {A2, A1} |
| in_weights | input | 32 | Packed weights {B2, B1} |
| guard_en | input | 1 | 1 = 40-bit accumulation, 0 = 32-bit wrap |
| acc0 | output | 40 | Accumulator 0, sign-extended |
| acc1 | output | 40 | Accumulator 1, sign-extended |
| ovf | output | 1 | Sticky overflow flag |
| res_valid | output | 1 | Strobe in the cycle after each accepted beat |

## Verification
A clear and an accepted beat can land in the same cycle. That single cycle then has to drop the old sum, load the new products, and restart the overflow flag, which may be set again by the same load. The bench issues clear together with valid in both modes, under both guard settings, and with extreme operands, including a dual load of four -32768 operands that overflows the 32-bit range at once. A behavioural model that uses wide integers computes the expected result every cycle, and explicit constant checks confirm the loaded values and the flag.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  localparam int ELEM_W  = 16;
  localparam int GUARD_W = 8;
  localparam int N_LANES = 2;

  typedef enum logic {
    MODE_DUAL = 1'b0,
    MODE_VEC  = 1'b1
  } vmac_mode_e;
endpackage

// File: rtl/vmac_mul.sv
module vmac_mul #(
  parameter int EW = 16
) (
  input  logic [EW-1:0]          a,
  input  logic [EW-1:0]          b,
  output logic signed [2*EW-1:0] p
);
  always_comb p = $signed(a) * $signed(b);
endmodule

// File: rtl/vmac_acc.sv
module vmac_acc #(
  parameter int PW = 32,
  parameter int GW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic                 guard,
  input  logic signed [PW:0]   addend,
  output logic [PW+GW-1:0]     acc_o,
  output logic                 ovf_o
);
  localparam int AW = PW + GW;
  localparam int SW = AW + 2;

  logic signed [AW-1:0] acc_q;
  logic                 ovf_q;
  logic signed [AW-1:0] base;
  logic signed [SW-1:0] base_x, add_x, sum;
  logic [AW-1:0]        nxt;
  logic                 fit_wide, fit_narrow, ovf_now;

  always_comb begin
    if (clr)        base = '0;
    else if (guard) base = acc_q;
    else            base = {{GW{acc_q[PW-1]}}, acc_q[PW-1:0]};
    base_x = base;
    add_x  = addend;
    sum    = base_x + add_x;
    fit_wide   = (sum[SW-1:AW-1] == '0) || (sum[SW-1:AW-1] == '1);
    fit_narrow = (sum[SW-1:PW-1] == '0) || (sum[SW-1:PW-1] == '1);
    nxt     = guard ? sum[AW-1:0] : {{GW{sum[PW-1]}}, sum[PW-1:0]};
    ovf_now = guard ? !fit_wide : !fit_narrow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd) begin
      acc_q <= nxt;
      ovf_q <= (clr ? 1'b0 : ovf_q) | ovf_now;
    end else if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/vmac_unit.sv
module vmac_unit #(
  parameter int EW = vmac_pkg::ELEM_W,
  parameter int GW = vmac_pkg::GUARD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_mode,
  input  logic                 in_clear,
  input  logic [2*EW-1:0]      in_samples,
  input  logic [2*EW-1:0]      in_weights,
  input  logic                 guard_en,
  output logic [2*EW+GW-1:0]   acc0,
  output logic [2*EW+GW-1:0]   acc1,
  output logic                 ovf,
  output logic                 res_valid
);
  import vmac_pkg::*;

  localparam int PW = 2 * EW;
  localparam int AW = PW + GW;
  localparam int NL = N_LANES;

  logic                 rdy_q, rv_q, accept, dual;
  logic signed [PW-1:0] prod [NL];
  logic signed [PW:0]   addend [NL];
  logic [NL-1:0]        upd, ovf_l;
  logic [AW-1:0]        acc_l [NL];

  assign accept = in_valid & rdy_q;
  assign dual   = (vmac_mode_e'(in_mode) == MODE_DUAL);

  genvar l;
  generate
    for (l = 0; l < NL; l++) begin : g_lane
      vmac_mul #(.EW(EW)) u_mul (
        .a (in_samples[l*EW +: EW]),
        .b (in_weights[l*EW +: EW]),
        .p (prod[l])
      );
    end
  endgenerate

  always_comb begin
    addend[0] = dual ? (PW+1)'(prod[0]) + (PW+1)'(prod[1]) : (PW+1)'(prod[0]);
    addend[1] = (PW+1)'(prod[1]);
    upd[0]    = accept;
    upd[1]    = accept & ~dual;
  end

  generate
    for (l = 0; l < NL; l++) begin : g_acc
      vmac_acc #(.PW(PW), .GW(GW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (in_clear),
        .upd    (upd[l]),
        .guard  (guard_en),
        .addend (addend[l]),
        .acc_o  (acc_l[l]),
        .ovf_o  (ovf_l[l])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      rv_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      rv_q  <= accept;
    end
  end

  assign in_ready  = rdy_q;
  assign res_valid = rv_q;
  assign acc0      = acc_l[0];
  assign acc1      = acc_l[1];
  assign ovf       = |ovf_l;
endmodule

// File: rtl/vmac_chk.sv
module vmac_chk #(
  parameter int EW = 16,
  parameter int GW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_mode,
  input logic               in_clear,
  input logic               guard_en,
  input logic [2*EW+GW-1:0] acc0,
  input logic [2*EW+GW-1:0] acc1,
  input logic               ovf,
  input logic               res_valid
);
  localparam int PW = 2 * EW;
  localparam int AW = PW + GW;

  // R1
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
  // R1
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);
  // R1
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !res_valid);
  // R3
  dual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_mode && !in_clear) |=> $stable(acc1));
  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !in_clear) |=> ($stable(acc0) && $stable(acc1)));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clear && !(in_valid && in_ready)) |=> (acc0 == '0 && acc1 == '0 && !ovf));
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard_en && in_valid && in_ready) |=>
      (acc0[AW-1:PW-1] == '0 || acc0[AW-1:PW-1] == '1));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !in_clear) |=> ovf);
endmodule

bind vmac_unit vmac_chk #(.EW(EW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_clear(in_clear), .guard_en(guard_en),
  .acc0(acc0), .acc1(acc1), .ovf(ovf), .res_valid(res_valid)
);

// File: tb/sim_vmac_unit.sv
`timescale 1ns/1ps
module sim_vmac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_mode = 1'b0, in_clear = 1'b0, guard_en = 1'b1;
  logic [31:0] in_samples = '0, in_weights = '0;
  logic        in_ready, ovf, res_valid;
  logic [39:0] acc0, acc1;

  int    total = 0, bad = 0;
  string ph = "R11";
  bit    rst_next = 1'b0;

  longint m0 = 0, m1 = 0;
  bit     mov = 0, mrv = 0, mrdy = 0;

  always #2.5 clk = ~clk;

  vmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_clear(in_clear), .in_samples(in_samples),
    .in_weights(in_weights), .guard_en(guard_en), .acc0(acc0), .acc1(acc1),
    .ovf(ovf), .res_valid(res_valid)
  );

  function automatic longint sx32(longint s);
    return longint'(int'(s));
  endfunction

  function automatic longint wrap40(longint s);
    return (s <<< 24) >>> 24;
  endfunction

  task automatic lane(inout longint m, input longint add, input bit clr, input bit g, output bit ov);
    longint base, s;
    base = clr ? 0 : (g ? m : sx32(m));
    s = base + add;
    if (g) begin
      ov = (s > 64'sd549755813887) || (s < -64'sd549755813888);
      m  = wrap40(s);
    end else begin
      ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      m  = sx32(s);
    end
  endtask

  task automatic model_step();
    bit acc, ov0, ov1;
    longint p0, p1;
    if (!rst_n) begin
      m0 = 0; m1 = 0; mov = 0; mrv = 0; mrdy = 0;
      return;
    end
    acc = in_valid && mrdy;
    p0 = longint'($signed(in_samples[15:0])) * longint'($signed(in_weights[15:0]));
    p1 = longint'($signed(in_samples[31:16])) * longint'($signed(in_weights[31:16]));
    ov0 = 0; ov1 = 0;
    if (acc) begin
      if (!in_mode) begin
        lane(m0, p0 + p1, in_clear, guard_en, ov0);
        if (in_clear) m1 = 0;
      end else begin
        lane(m0, p0, in_clear, guard_en, ov0);
        lane(m1, p1, in_clear, guard_en, ov1);
      end
      mov = (in_clear ? 1'b0 : mov) | ov0 | ov1;
    end else if (in_clear) begin
      m0 = 0; m1 = 0; mov = 0;
    end
    mrv  = acc;
    mrdy = 1;
  endtask

  task automatic cmp(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", ph, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("acc0", longint'($signed(acc0)), m0);
    cmp("acc1", longint'($signed(acc1)), m1);
    cmp("ovf", longint'(ovf), longint'(mov));
    cmp("res_valid", longint'(res_valid), longint'(mrv));
    cmp("in_ready", longint'(in_ready), longint'(mrdy));
  endtask

  task automatic cyc(bit v, bit clr, bit mode, logic [31:0] a, logic [31:0] b, bit g);
    @(negedge clk);
    check_all();
    rst_n = rst_next;
    in_valid = v; in_clear = clr; in_mode = mode;
    in_samples = a; in_weights = b; guard_en = g;
    model_step();
  endtask

  function automatic logic [15:0] rnd16();
    int k;
    k = $urandom_range(0, 7);
    if (k == 0) return 16'h8000;
    if (k == 1) return 16'h7fff;
    return 16'($urandom);
  endfunction

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired in %s", ph);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    // R11: reset state
    ph = "R11";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0, '0, 1);
    rst_next = 1'b1;
    ph = "R1";
    cyc(0, 0, 0, '0, '0, 1);
    cyc(0, 0, 0, '0, '0, 1);
    // R2: dual mode accumulation
    ph = "R2";
    cyc(1, 1, 0, {16'd3, 16'd2}, {16'd5, 16'd7}, 1);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, {rnd16(), rnd16()}, {rnd16(), rnd16()}, 1);
    // R3: accumulator 1 holds in dual mode, R5 idle holds both
    ph = "R3";
    cyc(1, 0, 1, {16'd9, 16'd1}, {16'd4, 16'd1}, 1);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, {rnd16(), rnd16()}, {rnd16(), rnd16()}, 1);
    ph = "R5";
    for (int i = 0; i < 5; i++) cyc(0, 0, i[0], {rnd16(), rnd16()}, {rnd16(), rnd16()}, 1);
    // R4: vector mode, stride-one shared weight
    ph = "R4";
    for (int i = 0; i < 20; i++) begin
      w = rnd16();
      cyc(1, 0, 1, {rnd16(), rnd16()}, {w, w}, 1);
    end
    // R6: clear alone
    ph = "R6";
    cyc(1, 0, 1, {16'd100, 16'd200}, {16'd3, 16'd3}, 1);
    cyc(0, 1, 1, '0, '0, 1);
    cyc(0, 0, 0, '0, '0, 1);
    // R7: clear with a beat, both modes
    ph = "R7";
    cyc(1, 0, 1, {16'd50, 16'd60}, {16'd2, 16'd2}, 1);
    cyc(1, 1, 1, {16'hfffe, 16'd11}, {16'd3, 16'd5}, 1);
    cyc(1, 1, 0, {16'd4, 16'd6}, {16'd10, 16'd10}, 1);
    cyc(0, 0, 0, '0, '0, 1);
    cmp("R7 dual load acc0", longint'($signed(acc0)), 100);
    cmp("R7 dual load acc1", longint'($signed(acc1)), 0);
    // R8/R10: 32-bit wrap with overflow on a clear-load
    ph = "R8";
    cyc(1, 1, 0, 32'h80008000, 32'h80008000, 0);
    cyc(0, 0, 0, '0, '0, 0);
    cmp("R8 wrapped acc0", longint'(acc0), 64'hFF80000000);
    cmp("R10 ovf after load", longint'(ovf), 1);
    ph = "R10";
    for (int i = 0; i < 4; i++) cyc(1, 0, i[0], {rnd16(), rnd16()}, {16'd0, 16'd0}, 0);
    cmp("R10 ovf sticky", longint'(ovf), 1);
    cyc(0, 1, 0, '0, '0, 0);
    cyc(0, 0, 0, '0, '0, 1);
    cmp("R10 ovf cleared", longint'(ovf), 0);
    // R9: 40-bit headroom
    ph = "R9";
    cyc(1, 1, 0, 32'h80008000, 32'h80008000, 1);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 32'h80008000, 32'h80008000, 1);
    cyc(0, 0, 0, '0, '0, 1);
    cmp("R9 acc0 2^33", longint'(acc0), 64'h0200000000);
    cmp("R9 no ovf", longint'(ovf), 0);
    // R10: overflow of the 40-bit range
    ph = "R10";
    for (int i = 0; i < 260; i++) cyc(1, 0, 0, 32'h80008000, 32'h80008000, 1);
    cyc(0, 0, 0, '0, '0, 1);
    cmp("R10 wide ovf", longint'(ovf), 1);
    // mixed random traffic, all requirements against the model
    ph = "R2/R4/R7/R8 random";
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0, 1'($urandom),
          {rnd16(), rnd16()}, {rnd16(), rnd16()}, ((i / 500) % 2) == 0);
    end
    cyc(0, 0, 0, '0, '0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule